// File: doc/BRIEF.md
# Subframe Grid Buffer Controller

The block sits behind an OFDM demodulator. It takes in demodulated resource elements as a stream. Each element carries a valid flag, a subframe number, an OFDM symbol index and a subcarrier bin. The block captures one chosen subframe into a grid memory. Each stored element is placed at the address formed from its symbol and its bin.

While that subframe is being captured, the block recognises the cell-specific reference elements from the cell identity and forwards each one as it arrives. Each forwarded element is tagged with its symbol, its bin and the antenna port it belongs to, so a channel estimator can work in parallel with the store.

When the last element of the subframe has been stored, a done flag rises. From then on the same output port returns stored elements fetched by a read address. A downstream indexer and equaliser use this port to pull out the channel they need. A restart pulse, given on a new cell detection, drops the done flag and re-arms the capture for the next occurrence of the chosen subframe.

Top module: `sfGridBuffer`

## Requirements
- R1: After reset, writeDone and outValid are both 0.
- R2: Capture starts only on a valid element of the subframe equal to storeSubframe that has symbol 0 and bin 0. From then on, valid elements of that subframe are stored and elements of other subframes are ignored.
- R3: An element with symbol s and bin b is stored at read address {s, b}: the symbol in the upper SYM_W bits and the bin in the lower BIN_W bits. Reading that address returns the element's real and imaginary parts unchanged.
- R4: writeDone rises in the cycle after the element with symbol NUM_SYM-1 and bin NUM_BINS-1 is stored. After that, no input element is stored and none is forwarded.
- R5: When writeDone is 1, rdEn with an address whose symbol field is below NUM_SYM gives, one cycle later, outValid=1, the stored data, outSymbol and outBin taken from the address, and outPort=0. rdEn gives no output when writeDone is 0 or when the symbol field is NUM_SYM or more.
- R6: While a subframe is being stored, a stored element in symbol 0, 4, 7 or 11 is forwarded one cycle later when (bin mod 6) equals k0 or k1. The forwarded element carries its data, symbol and bin. k0 is (cellId mod 6) on symbols 0 and 7, and (cellId mod 6 + 3) mod 6 on symbols 4 and 11. k1 is (k0 + 3) mod 6. Every other element gives outValid=0.
- R7: A forwarded reference element has outPort=0 when (bin mod 6)=k0 and outPort=1 when (bin mod 6)=k1.
- R8: A restartIn pulse forces writeDone to 0 in the next cycle and abandons any partial capture. Capture then waits again for symbol 0, bin 0 of the selected subframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| restartIn | input | 1 | Cell-detected / restart pulse; re-arms capture |
| cellId | input | 9 | Physical cell identity, 0 to 503 |
| storeSubframe | input | 4 | Subframe number to capture |
| inValid | input | 1 | Input element valid |
| inSubframe | input | 4 | Subframe number of the input element |
| inSymbol | input | SYM_W | OFDM symbol index of the input element |
| inBin | input | BIN_W | Subcarrier bin of the input element |
| inRe | input | DATA_W | Real part of the input element |
| inIm | input | DATA_W | Imaginary part of the input element |
| rdEn | input | 1 | Read request |
| rdAddr | input | SYM_W+BIN_W | Read address {symbol, bin} |
| writeDone | output | 1 | Subframe stored; the output port carries read data |
| outValid | output | 1 | Output element valid |
| outRe | output | DATA_W | Real part of the output element |
| outIm | output | DATA_W | Imaginary part of the output element |
| outSymbol | output | SYM_W | Symbol index of the output element |
| outBin | output | BIN_W | Bin of the output element |
| outPort | output | 1 | Antenna port of a reference element, 0 on reads |

## Verification
The hardest case to reach from the ports is a restart that arrives in the middle of a capture, followed by the rest of the same subframe. Those later elements belong to the selected subframe, yet they must be neither stored nor forwarded, because the start element has not been seen again. The stimulus streams half of a selected subframe and pulses restart. It then streams the second half and checks that it stays silent. Finally it sends a complete subframe with different data and reads it back, which shows that only that later capture reached memory. The table rows sweep cell identities whose reference offsets wrap past bin 6, and store subframes other than 0.

// File: rtl/sgbPkg.sv
package sgbPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_DONE
  } sgbState_t;

  typedef struct packed {
    logic wrEn;    // store the current input element
    logic rsHit;   // current input element is a reference element
    logic rsPort;  // antenna port of that reference element
    logic rdFire;  // accepted memory read
  } sgbStrobes_t;

endpackage

// File: rtl/sgbRsLocator.sv
module sgbRsLocator #(
  parameter int SYM_W = 4,
  parameter int BIN_W = 6
) (
  input  logic [8:0]       cellId,
  input  logic [SYM_W-1:0] sym,
  input  logic [BIN_W-1:0] bin,
  output logic             hit,
  output logic             port
);

  localparam int STEP = 6;
  localparam int HALF = STEP / 2;

  logic [2:0] cellMod;
  logic [2:0] binMod;
  logic [2:0] k0;
  logic [2:0] k1;
  logic       rsSym;
  logic       groupA;

  always_comb begin
    cellMod = 3'(32'(cellId) % STEP);
    binMod  = 3'(32'(bin) % STEP);
    groupA  = (sym == SYM_W'(0)) || (sym == SYM_W'(7));
    rsSym   = groupA || (sym == SYM_W'(4)) || (sym == SYM_W'(11));
    if (groupA) k0 = cellMod;
    else        k0 = (cellMod >= 3'(HALF)) ? cellMod - 3'(HALF) : cellMod + 3'(HALF);
    k1   = (k0 >= 3'(HALF)) ? k0 - 3'(HALF) : k0 + 3'(HALF);
    hit  = rsSym && ((binMod == k0) || (binMod == k1));
    port = (binMod == k1);
  end

endmodule

// File: rtl/sgbCtrl.sv
module sgbCtrl
  import sgbPkg::*;
#(
  parameter int NUM_SYM  = 14,
  parameter int NUM_BINS = 64,
  parameter int SYM_W    = 4,
  parameter int BIN_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              restartIn,
  input  logic [8:0]        cellId,
  input  logic [3:0]        storeSubframe,
  input  logic              inValid,
  input  logic [3:0]        inSubframe,
  input  logic [SYM_W-1:0]  inSymbol,
  input  logic [BIN_W-1:0]  inBin,
  input  logic              rdEn,
  input  logic [SYM_W-1:0]  rdSymbol,
  output sgbStrobes_t       strobes,
  output logic              writeDone
);

  localparam logic [SYM_W-1:0] LAST_SYM = SYM_W'(NUM_SYM - 1);
  localparam logic [BIN_W-1:0] LAST_BIN = BIN_W'(NUM_BINS - 1);

  sgbState_t state;
  sgbState_t stateNext;
  logic      sfMatch;
  logic      isFirst;
  logic      isLast;
  logic      rsHitRaw;
  logic      rsPortRaw;

  sgbRsLocator #(
    .SYM_W(SYM_W),
    .BIN_W(BIN_W)
  ) u_locator (
    .cellId(cellId),
    .sym   (inSymbol),
    .bin   (inBin),
    .hit   (rsHitRaw),
    .port  (rsPortRaw)
  );

  always_comb begin
    sfMatch = inValid && (inSubframe == storeSubframe) && (inSymbol <= LAST_SYM);
    isFirst = (inSymbol == '0) && (inBin == '0);
    isLast  = (inSymbol == LAST_SYM) && (inBin == LAST_BIN);

    strobes.wrEn   = !restartIn && sfMatch &&
                     (((state == ST_IDLE) && isFirst) || (state == ST_FILL));
    strobes.rsHit  = strobes.wrEn && rsHitRaw;
    strobes.rsPort = rsPortRaw;
    strobes.rdFire = !restartIn && (state == ST_DONE) && rdEn && (rdSymbol <= LAST_SYM);

    stateNext = state;
    if (restartIn) begin
      stateNext = ST_IDLE;
    end else if (strobes.wrEn) begin
      stateNext = isLast ? ST_DONE : ST_FILL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign writeDone = (state == ST_DONE);

  a_r2_selected_only: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |-> (inValid && inSubframe == storeSubframe));

  a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeDone) |-> $past(inValid && inSymbol == LAST_SYM && inBin == LAST_BIN));

  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rstN)
    restartIn |=> !writeDone);

endmodule

// File: rtl/sgbData.sv
module sgbData
  import sgbPkg::*;
#(
  parameter int NUM_SYM  = 14,
  parameter int NUM_BINS = 64,
  parameter int SYM_W    = 4,
  parameter int BIN_W    = 6,
  parameter int DATA_W   = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  sgbStrobes_t             strobes,
  input  logic [SYM_W-1:0]        inSymbol,
  input  logic [BIN_W-1:0]        inBin,
  input  logic [DATA_W-1:0]       inRe,
  input  logic [DATA_W-1:0]       inIm,
  input  logic [SYM_W+BIN_W-1:0]  rdAddr,
  output logic                    outValid,
  output logic [DATA_W-1:0]       outRe,
  output logic [DATA_W-1:0]       outIm,
  output logic [SYM_W-1:0]        outSymbol,
  output logic [BIN_W-1:0]        outBin,
  output logic                    outPort
);

  localparam int DEPTH  = NUM_SYM * NUM_BINS;
  localparam int WORD_W = 2 * DATA_W;

  logic [WORD_W-1:0] gridMem [DEPTH];
  logic [SYM_W+BIN_W-1:0] wrAddr;

  assign wrAddr = {inSymbol, inBin};

  always_ff @(posedge clk) begin
    if (strobes.wrEn) gridMem[wrAddr] <= {inRe, inIm};
  end

  always_ff @(posedge clk) begin
    if (strobes.rsHit) begin
      outRe     <= inRe;
      outIm     <= inIm;
      outSymbol <= inSymbol;
      outBin    <= inBin;
      outPort   <= strobes.rsPort;
    end else if (strobes.rdFire) begin
      {outRe, outIm} <= gridMem[rdAddr];
      outSymbol      <= rdAddr[SYM_W+BIN_W-1:BIN_W];
      outBin         <= rdAddr[BIN_W-1:0];
      outPort        <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= strobes.rsHit || strobes.rdFire;
  end

  a_r5_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdFire |=> (outValid && !outPort));

  a_r6_rs_forward: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rsHit |=> (outValid && outSymbol == $past(inSymbol) && outBin == $past(inBin)));

endmodule

// File: rtl/sfGridBuffer.sv
module sfGridBuffer
  import sgbPkg::*;
#(
  parameter int NUM_SYM  = 14,
  parameter int NUM_BINS = 64,
  parameter int DATA_W   = 16,
  parameter int SYM_W    = $clog2(NUM_SYM),
  parameter int BIN_W    = $clog2(NUM_BINS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    restartIn,
  input  logic [8:0]              cellId,
  input  logic [3:0]              storeSubframe,
  input  logic                    inValid,
  input  logic [3:0]              inSubframe,
  input  logic [SYM_W-1:0]        inSymbol,
  input  logic [BIN_W-1:0]        inBin,
  input  logic [DATA_W-1:0]       inRe,
  input  logic [DATA_W-1:0]       inIm,
  input  logic                    rdEn,
  input  logic [SYM_W+BIN_W-1:0]  rdAddr,
  output logic                    writeDone,
  output logic                    outValid,
  output logic [DATA_W-1:0]       outRe,
  output logic [DATA_W-1:0]       outIm,
  output logic [SYM_W-1:0]        outSymbol,
  output logic [BIN_W-1:0]        outBin,
  output logic                    outPort
);

  sgbStrobes_t strobes;

  sgbCtrl #(
    .NUM_SYM (NUM_SYM),
    .NUM_BINS(NUM_BINS),
    .SYM_W   (SYM_W),
    .BIN_W   (BIN_W)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .restartIn    (restartIn),
    .cellId       (cellId),
    .storeSubframe(storeSubframe),
    .inValid      (inValid),
    .inSubframe   (inSubframe),
    .inSymbol     (inSymbol),
    .inBin        (inBin),
    .rdEn         (rdEn),
    .rdSymbol     (rdAddr[SYM_W+BIN_W-1:BIN_W]),
    .strobes      (strobes),
    .writeDone    (writeDone)
  );

  sgbData #(
    .NUM_SYM (NUM_SYM),
    .NUM_BINS(NUM_BINS),
    .SYM_W   (SYM_W),
    .BIN_W   (BIN_W),
    .DATA_W  (DATA_W)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .inSymbol (inSymbol),
    .inBin    (inBin),
    .inRe     (inRe),
    .inIm     (inIm),
    .rdAddr   (rdAddr),
    .outValid (outValid),
    .outRe    (outRe),
    .outIm    (outIm),
    .outSymbol(outSymbol),
    .outBin   (outBin),
    .outPort  (outPort)
  );

  a_r1_quiet_reset: assert property (@(posedge clk)
    !rstN |=> (!writeDone && !outValid));

endmodule

// File: tb/sfGridBuffer_bench.sv
module sfGridBuffer_bench;

  localparam int NSYM  = 14;
  localparam int NBINS = 32;
  localparam int SW    = 4;
  localparam int BW    = 5;
  localparam int DW    = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          restartIn = 1'b0;
  logic [8:0]    cellId = '0;
  logic [3:0]    storeSubframe = '0;
  logic          inValid = 1'b0;
  logic [3:0]    inSubframe = '0;
  logic [SW-1:0] inSymbol = '0;
  logic [BW-1:0] inBin = '0;
  logic [DW-1:0] inRe = '0;
  logic [DW-1:0] inIm = '0;
  logic          rdEn = 1'b0;
  logic [SW+BW-1:0] rdAddr = '0;
  logic          writeDone;
  logic          outValid;
  logic [DW-1:0] outRe;
  logic [DW-1:0] outIm;
  logic [SW-1:0] outSymbol;
  logic [BW-1:0] outBin;
  logic          outPort;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;
  int  firstRsBin;

  always #5 clk = ~clk;

  sfGridBuffer #(
    .NUM_SYM (NSYM),
    .NUM_BINS(NBINS),
    .DATA_W  (DW)
  ) u_sfGridBuffer (
    .clk(clk), .rstN(rstN), .restartIn(restartIn), .cellId(cellId),
    .storeSubframe(storeSubframe), .inValid(inValid), .inSubframe(inSubframe),
    .inSymbol(inSymbol), .inBin(inBin), .inRe(inRe), .inIm(inIm),
    .rdEn(rdEn), .rdAddr(rdAddr), .writeDone(writeDone), .outValid(outValid),
    .outRe(outRe), .outIm(outIm), .outSymbol(outSymbol), .outBin(outBin),
    .outPort(outPort)
  );

  // rows: cellId, storeSubframe, data seed, expected port-0 bin offset in symbol 0
  localparam logic [32:0] VECS [4] = '{
    {9'd0,   4'd0, 12'h1a1, 8'd0},
    {9'd76,  4'd0, 12'h2b2, 8'd4},
    {9'd3,   4'd5, 12'h3c3, 8'd3},
    {9'd503, 4'd9, 12'h4d4, 8'd5}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] reOf(int seed, int sym);
    return {12'(seed), 4'(sym)};
  endfunction

  function automatic logic [DW-1:0] imOf(int seed, int bin);
    return {8'(bin), 8'(seed)};
  endfunction

  // -1: not a reference element, else antenna port (R6, R7 formula)
  function automatic int rsPortOf(int cid, int sym, int bin);
    int base, k0, k1;
    if (!(sym == 0 || sym == 4 || sym == 7 || sym == 11)) return -1;
    base = cid % 6;
    k0 = (sym == 0 || sym == 7) ? base : (base + 3) % 6;
    k1 = (k0 + 3) % 6;
    if (bin % 6 == k0) return 0;
    if (bin % 6 == k1) return 1;
    return -1;
  endfunction

  // called at a negedge; leaves at the next negedge after checking the output
  task automatic sendSample(int sf, int sym, int bin, int seed, bit accept, int cid);
    int p;
    inValid = 1'b1;
    inSubframe = 4'(sf);
    inSymbol = SW'(sym);
    inBin = BW'(bin);
    inRe = reOf(seed, sym);
    inIm = imOf(seed, bin);
    @(negedge clk);
    p = accept ? rsPortOf(cid, sym, bin) : -1;
    if (p < 0) begin
      check(outValid == 1'b0, "R6", "non-reference element forwarded", 64'(outValid), 64'd0);
    end else begin
      check(outValid && outSymbol == SW'(sym) && outBin == BW'(bin) &&
            outRe == reOf(seed, sym) && outIm == imOf(seed, bin),
            "R6", "reference element tag/data",
            {outValid, 7'd0, 4'd0, outSymbol, 3'd0, outBin, outRe, outIm},
            {8'd1, 4'd0, SW'(sym), 3'd0, BW'(bin), reOf(seed, sym), imOf(seed, bin)});
      check(outPort == 1'(p), "R7", "antenna port", 64'(outPort), 64'(p));
      if (sym == 0 && p == 0 && firstRsBin < 0) firstRsBin = bin;
    end
    inValid = 1'b0;
  endtask

  task automatic sendSymbols(int sf, int seed, bit accept, int cid, int s0, int s1);
    for (int s = s0; s <= s1; s++)
      for (int b = 0; b < NBINS; b++)
        sendSample(sf, s, b, seed, accept, cid);
  endtask

  task automatic readOne(int sym, int bin, int seed, string req);
    rdEn = 1'b1;
    rdAddr = {SW'(sym), BW'(bin)};
    @(negedge clk);
    rdEn = 1'b0;
    check(outValid && outRe == reOf(seed, sym) && outIm == imOf(seed, bin) &&
          outSymbol == SW'(sym) && outBin == BW'(bin) && !outPort,
          req, "read back", {outValid, outPort, 14'd0, outRe, outIm},
          {16'h8000, reOf(seed, sym), imOf(seed, bin)});
  endtask

  task automatic pulseRestart();
    restartIn = 1'b1;
    @(negedge clk);
    restartIn = 1'b0;
    check(writeDone == 1'b0, "R8", "writeDone after restart", 64'(writeDone), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(writeDone == 1'b0, "R1", "writeDone in reset", 64'(writeDone), 64'd0);
    check(outValid == 1'b0, "R1", "outValid in reset", 64'(outValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(writeDone == 1'b0 && outValid == 1'b0, "R1", "idle after reset",
          {writeDone, outValid}, 64'd0);

    // table-driven rows
    for (int r = 0; r < 4; r++) begin
      int cid, sf, seed, expK;
      cid  = int'(VECS[r][32:24]);
      sf   = int'(VECS[r][23:20]);
      seed = int'(VECS[r][19:8]);
      expK = int'(VECS[r][7:0]);
      cellId = 9'(cid);
      storeSubframe = 4'(sf);
      pulseRestart();
      firstRsBin = -1;
      sendSymbols((sf + 9) % 10, seed + 1, 1'b0, cid, 0, NSYM - 1);   // R2 other subframe
      check(writeDone == 1'b0, "R2", "no capture from other subframe", 64'(writeDone), 64'd0);
      sendSymbols(sf, seed, 1'b1, cid, 0, NSYM - 1);
      check(writeDone == 1'b1, "R4", "writeDone after last element", 64'(writeDone), 64'd1);
      check(firstRsBin == expK, "R6", "first port-0 bin in symbol 0", 64'(firstRsBin), 64'(expK));
      sendSymbols(sf, seed + 2, 1'b0, cid, 0, NSYM - 1);               // R4 frozen
      check(writeDone == 1'b1, "R4", "writeDone held", 64'(writeDone), 64'd1);
      for (int s = 0; s < NSYM; s++)
        for (int b = 0; b < NBINS; b++)
          readOne(s, b, seed, "R3");
    end

    // R5: read beyond the last symbol gives nothing
    rdEn = 1'b1;
    rdAddr = {SW'(NSYM), BW'(0)};
    @(negedge clk);
    rdEn = 1'b0;
    check(outValid == 1'b0, "R5", "read of symbol NUM_SYM", 64'(outValid), 64'd0);

    // R5: read while writeDone low gives nothing
    cellId = 9'd76;
    storeSubframe = 4'd0;
    pulseRestart();
    rdEn = 1'b1;
    rdAddr = '0;
    @(negedge clk);
    rdEn = 1'b0;
    check(outValid == 1'b0, "R5", "read with writeDone low", 64'(outValid), 64'd0);

    // R2: selected subframe not starting at symbol 0 bin 0 is not captured
    sendSample(0, 0, 1, 12'h555, 1'b0, 76);
    sendSample(0, 0, 4, 12'h555, 1'b0, 76);
    check(writeDone == 1'b0, "R2", "no start on bin 1", 64'(writeDone), 64'd0);

    // R8: restart in the middle of a capture
    sendSymbols(0, 12'h666, 1'b1, 76, 0, 6);
    pulseRestart();
    sendSymbols(0, 12'h666, 1'b0, 76, 7, NSYM - 1);
    check(writeDone == 1'b0, "R8", "abandoned capture not done", 64'(writeDone), 64'd0);
    sendSymbols(0, 12'h777, 1'b1, 76, 0, NSYM - 1);
    check(writeDone == 1'b1, "R8", "recapture completes", 64'(writeDone), 64'd1);
    readOne(0, 0, 12'h777, "R8");
    readOne(6, NBINS - 1, 12'h777, "R8");
    readOne(NSYM - 1, 3, 12'h777, "R8");

    // R8: restart from the done state
    pulseRestart();
    check(outValid == 1'b0, "R8", "quiet after restart", 64'(outValid), 64'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule